// File: doc/BRIEF.md
# SPI Controller Channel Engine

This block is the serial core of one channel of an SPI controller. It takes words from a single-entry transmit holding register, shifts them out most significant bit first on a serial clock it builds from an external edge strobe, and assembles incoming bits into a right-justified receive word. Word size, clock idle level and sampling phase, chip-select polarity, transfer direction, the role of each of the two data lines and the number of words per transfer are all set through static configuration inputs. The configuration is changed only while the channel is disabled.

Each pulse on `sclk_tick` is one serial clock edge, so a word of W bits takes 2W strobes. A transfer runs until a programmed number of words has completed, at which point an end-of-transfer flag rises. Between words the engine normally spends one strobe idle. In back-to-back mode, a waiting word follows the previous one on the very next strobe. In receive-only mode, one write to the transmit port starts the engine, which then clocks out zeros. The channel enable is also the abort: dropping it returns everything to idle.

Top module: `spi_chan_engine`

## Requirements
- R1: `cfg_wlen_m1` holds the word size minus one. Sizes 4 to 32 bits are legal, and a field value below 3 behaves as a 4-bit word. Words leave MSB first, and transmit bits above the word size never appear on a data line.
- R2: When no word is shifting, `sclk` rests at `cfg_cpol`. It toggles once per `sclk_tick` during a word. With `cfg_cpha`=0 a bit is sampled on the first edge of its pair and changes on the second. With `cfg_cpha`=1 it changes on the first edge and is sampled on the second.
- R3: `cfg_mode` 00 is full duplex, 01 is receive only and 10 is transmit only. In transmit only, `rx_full` never rises.
- R4: In receive only, no word starts until a transmit write arrives. The data of that write is discarded. Zeros are shifted out, and words then follow on their own until end of transfer or until the channel is disabled.
- R5: `cfg_in_sel`=0 samples data line 0 and `cfg_in_sel`=1 samples data line 1.
- R6: `cfg_oe0` and `cfg_oe1` each let one data line drive the transmit bit. A line drives only while a word is shifting.
- R7: `cs_o` is low when active if `cfg_cs_act_low`=1, and high when active if it is 0. It is active while a word shifts. With `cfg_force`=1 it stays active for as long as the channel is enabled.
- R8: `eot` rises on the strobe that completes word number `cfg_wcnt`. After that, no new word starts until the channel is re-enabled. A count of 0 means no limit.
- R9: With `cfg_turbo`=1, a word that is ready when a word ends starts on the next strobe, unless the word that just ended was the last one. Otherwise exactly one strobe passes idle, with `sclk` unchanged and chip select released unless forced.
- R10: At the end of each word, the received bits land right-justified in `rx_data` with the upper bits zero, and `rx_full` sets. `rx_rd` clears `rx_full`. `tx_empty` falls on an accepted write, and a write while it is low is ignored.
- R11: After reset, and after `enable` falls, the engine is idle. Chip select is inactive, `sclk` equals `cfg_cpol`, both lines are undriven, `tx_empty`=1, and `rx_full`=0 and `eot`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Channel enable; low aborts and idles |
| cfg_wlen_m1 | input | 5 | Word size minus one |
| cfg_mode | input | 2 | Transfer direction |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling phase |
| cfg_cs_act_low | input | 1 | Chip select active low when 1 |
| cfg_force | input | 1 | Hold chip select while enabled |
| cfg_turbo | input | 1 | Back-to-back words |
| cfg_in_sel | input | 1 | Input data line select |
| cfg_oe0 | input | 1 | Drive data line 0 |
| cfg_oe1 | input | 1 | Drive data line 1 |
| cfg_wcnt | input | 16 | Words per transfer, 0 = unlimited |
| sclk_tick | input | 1 | One serial clock edge strobe |
| tx_wr | input | 1 | Transmit write |
| tx_data | input | 32 | Transmit word |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_rd | input | 1 | Receive read acknowledge |
| rx_data | output | 32 | Received word |
| rx_full | output | 1 | Receive word waiting |
| eot | output | 1 | End of transfer |
| sclk | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| d0_i | input | 1 | Data line 0 input |
| d0_o | output | 1 | Data line 0 output |
| d0_oe | output | 1 | Data line 0 drive enable |
| d1_i | input | 1 | Data line 1 input |
| d1_o | output | 1 | Data line 1 output |
| d1_oe | output | 1 | Data line 1 drive enable |

## Verification
The bench covers all four clock phase and polarity pairs. A design that sampled on the wrong edge of a pair would return the slave word shifted by one bit. It also runs word sizes at both limits and a field value below the legal minimum. A wrong clamp or a missing mask would leak upper transmit bits or leave stale upper receive bits. Further cases are the chained back-to-back transfer against the one-strobe gap, receive-only start on a dummy write, the ignored write to a full holding register, and an abort in the middle of a word. A design that got these wrong would show an sclk strobe that fails to toggle, a word starting early or late, the wrong word on the line, or sclk left at the wrong level after the abort.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
   localparam logic [1:0] MODE_DUPLEX  = 2'b00;
   localparam logic [1:0] MODE_RX_ONLY = 2'b01;
   localparam logic [1:0] MODE_TX_ONLY = 2'b10;

   typedef enum logic [1:0] {
      ST_READY = 2'b00,
      ST_SHIFT = 2'b01,
      ST_GAP   = 2'b10
   } eng_state_t;
endpackage

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
   parameter int MAX_W = 32,
   localparam int WL_W = $clog2(MAX_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MAX_W-1:0] load_val,
   input  logic             shift_out,
   input  logic             sample,
   input  logic             din,
   input  logic [WL_W-1:0]  wl_m1,
   output logic             dout,
   output logic [MAX_W-1:0] rx_next
);
   logic [MAX_W-1:0] tx_sr;
   logic [MAX_W-1:0] rx_sr;

   // outgoing bit sits at the top of the active word
   assign dout    = tx_sr[wl_m1];
   assign rx_next = sample ? {rx_sr[MAX_W-2:0], din} : rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr <= '0;
         rx_sr <= '0;
      end else if (load) begin
         tx_sr <= load_val;
         rx_sr <= '0;
      end else begin
         if (shift_out) tx_sr <= tx_sr << 1;
         if (sample)    rx_sr <= {rx_sr[MAX_W-2:0], din};
      end
   end
endmodule

// File: rtl/spi_eng_wordcnt.sv
module spi_eng_wordcnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [CNT_W-1:0] limit,
   output logic             last_word,
   output logic             eot
);
   logic [CNT_W-1:0] done_cnt;

   assign last_word = (limit != '0) && (done_cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_cnt <= '0;
         eot      <= 1'b0;
      end else if (clr) begin
         done_cnt <= '0;
         eot      <= 1'b0;
      end else if (step) begin
         done_cnt <= done_cnt + 1'b1;
         if (last_word) eot <= 1'b1;
      end
   end
endmodule

// File: rtl/spi_chan_engine.sv
module spi_chan_engine
   import spi_eng_pkg::*;
#(
   parameter int MAX_W = 32,
   parameter int MIN_W = 4,
   parameter int CNT_W = 16,
   localparam int WL_W = $clog2(MAX_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [WL_W-1:0]  cfg_wlen_m1,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_cpol,
   input  logic             cfg_cpha,
   input  logic             cfg_cs_act_low,
   input  logic             cfg_force,
   input  logic             cfg_turbo,
   input  logic             cfg_in_sel,
   input  logic             cfg_oe0,
   input  logic             cfg_oe1,
   input  logic [CNT_W-1:0] cfg_wcnt,
   input  logic             sclk_tick,
   input  logic             tx_wr,
   input  logic [MAX_W-1:0] tx_data,
   output logic             tx_empty,
   input  logic             rx_rd,
   output logic [MAX_W-1:0] rx_data,
   output logic             rx_full,
   output logic             eot,
   output logic             sclk,
   output logic             cs_o,
   input  logic             d0_i,
   output logic             d0_o,
   output logic             d0_oe,
   input  logic             d1_i,
   output logic             d1_o,
   output logic             d1_oe
);
   localparam int EC_W = WL_W + 1;
   localparam logic [WL_W-1:0] WL_FLOOR = WL_W'(MIN_W - 1);

   if (MIN_W < 2 || MAX_W < MIN_W || (MAX_W & (MAX_W - 1)) != 0) begin : g_bad_cfg
      $error("spi_chan_engine: word size parameters out of range");
   end

   eng_state_t       state;
   logic [WL_W-1:0]  wl_m1;
   logic [MAX_W-1:0] wmask;
   logic [MAX_W-1:0] hold;
   logic             hold_full;
   logic             run;
   logic [EC_W-1:0]  ecnt;
   logic             sclk_q;
   logic             rxo, txo, shifting, tk, last_edge;
   logic             sample, shift_out, word_done;
   logic             have_next, start, chain, load, last_word;
   logic             dbit, din, cs_active;
   logic [MAX_W-1:0] rx_next;

   assign wl_m1 = (cfg_wlen_m1 < WL_FLOOR) ? WL_FLOOR : cfg_wlen_m1;

   for (genvar gi = 0; gi < MAX_W; gi++) begin : g_mask
      assign wmask[gi] = (WL_W'(gi) <= wl_m1);
   end

   assign rxo       = (cfg_mode == MODE_RX_ONLY);
   assign txo       = (cfg_mode == MODE_TX_ONLY);
   assign shifting  = (state == ST_SHIFT);
   assign tk        = sclk_tick && shifting;
   assign last_edge = (ecnt == {wl_m1, 1'b1});
   assign sample    = tk && (ecnt[0] == cfg_cpha);
   assign shift_out = tk && (ecnt[0] != cfg_cpha) && (ecnt != '0);
   assign word_done = tk && last_edge;
   assign have_next = rxo ? run : hold_full;
   assign start     = enable && (state == ST_READY) && have_next && !eot;
   assign chain     = word_done && cfg_turbo && have_next && !last_word;
   assign load      = start || chain;
   assign din       = cfg_in_sel ? d1_i : d0_i;

   spi_eng_shifter #(.MAX_W(MAX_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_val  (rxo ? '0 : hold),
      .shift_out (shift_out),
      .sample    (sample),
      .din       (din),
      .wl_m1     (wl_m1),
      .dout      (dbit),
      .rx_next   (rx_next)
   );

   spi_eng_wordcnt #(.CNT_W(CNT_W)) u_wcnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (!enable),
      .step      (word_done),
      .limit     (cfg_wcnt),
      .last_word (last_word),
      .eot       (eot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         hold_full <= 1'b0;
         run       <= 1'b0;
      end else if (!enable) begin
         hold_full <= 1'b0;
         run       <= 1'b0;
      end else begin
         if (load && !rxo) hold_full <= 1'b0;
         if (tx_wr && !hold_full) begin
            if (rxo) begin
               run <= 1'b1;
            end else begin
               hold      <= tx_data;
               hold_full <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_READY;
      end else if (!enable) begin
         state <= ST_READY;
      end else begin
         case (state)
            ST_READY: if (start) state <= ST_SHIFT;
            ST_SHIFT: if (word_done) state <= chain ? ST_SHIFT : ST_GAP;
            ST_GAP:   if (sclk_tick) state <= ST_READY;
            default:  state <= ST_READY;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt   <= '0;
         sclk_q <= 1'b0;
      end else begin
         if (load)    ecnt <= '0;
         else if (tk) ecnt <= ecnt + 1'b1;
         if (enable && shifting) begin
            if (sclk_tick) sclk_q <= ~sclk_q;
         end else begin
            sclk_q <= cfg_cpol;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_full <= 1'b0;
      end else if (!enable) begin
         rx_full <= 1'b0;
      end else if (word_done && !txo) begin
         rx_data <= rx_next & wmask;
         rx_full <= 1'b1;
      end else if (rx_rd) begin
         rx_full <= 1'b0;
      end
   end

   assign cs_active = enable && (cfg_force || shifting);
   assign cs_o      = cfg_cs_act_low ? ~cs_active : cs_active;
   assign sclk      = sclk_q;
   assign tx_empty  = !hold_full;
   assign d0_o      = dbit;
   assign d1_o      = dbit;
   assign d0_oe     = cfg_oe0 && shifting && enable;
   assign d1_oe     = cfg_oe1 && shifting && enable;
endmodule

// File: rtl/spi_chan_engine_chk.sv
module spi_chan_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       sclk_tick,
   input logic       cfg_cpol,
   input logic       cfg_cs_act_low,
   input logic [1:0] cfg_mode,
   input logic       tx_wr,
   input logic       tx_empty,
   input logic       rx_full,
   input logic       eot,
   input logic       sclk,
   input logic       cs_o
);
   // R2
   sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !sclk_tick && $stable(cfg_cpol)) |=> $stable(sclk));

   // R11
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(enable) |=> (tx_empty && !rx_full && !eot));

   // R7
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (cs_o == cfg_cs_act_low));

   // R8
   eot_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eot) |-> $past(sclk_tick));

   // R8
   eot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eot && enable) |=> eot);

   // R10
   tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> $past(tx_wr));

   // R3
   txonly_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> (cfg_mode != 2'b10));
endmodule

bind spi_chan_engine spi_chan_engine_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .enable         (enable),
   .sclk_tick      (sclk_tick),
   .cfg_cpol       (cfg_cpol),
   .cfg_cs_act_low (cfg_cs_act_low),
   .cfg_mode       (cfg_mode),
   .tx_wr          (tx_wr),
   .tx_empty       (tx_empty),
   .rx_full        (rx_full),
   .eot            (eot),
   .sclk           (sclk),
   .cs_o           (cs_o)
);

// File: tb/spi_chan_engine_bench.sv
module spi_chan_engine_bench;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        enable = 0;
   logic [4:0]  cfg_wlen_m1 = 5'd7;
   logic [1:0]  cfg_mode = 2'b00;
   logic        cfg_cpol = 0, cfg_cpha = 0, cfg_cs_act_low = 1;
   logic        cfg_force = 0, cfg_turbo = 0, cfg_in_sel = 0;
   logic        cfg_oe0 = 0, cfg_oe1 = 1;
   logic [15:0] cfg_wcnt = 16'd1;
   logic        sclk_tick = 0, tx_wr = 0, rx_rd = 0;
   logic [31:0] tx_data = '0;
   logic        d0_i = 0, d1_i = 0;
   logic        tx_empty, rx_full, eot, sclk, cs_o;
   logic [31:0] rx_data;
   logic        d0_o, d0_oe, d1_o, d1_oe;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   spi_chan_engine u_spi_chan_engine (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wlen_m1(cfg_wlen_m1),
      .cfg_mode(cfg_mode), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_cs_act_low(cfg_cs_act_low), .cfg_force(cfg_force), .cfg_turbo(cfg_turbo),
      .cfg_in_sel(cfg_in_sel), .cfg_oe0(cfg_oe0), .cfg_oe1(cfg_oe1), .cfg_wcnt(cfg_wcnt),
      .sclk_tick(sclk_tick), .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
      .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .eot(eot), .sclk(sclk),
      .cs_o(cs_o), .d0_i(d0_i), .d0_o(d0_o), .d0_oe(d0_oe), .d1_i(d1_i), .d1_o(d1_o),
      .d1_oe(d1_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] wmask(input int w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
   endfunction

   task automatic tick();
      @(negedge clk) sclk_tick = 1;
      @(negedge clk) sclk_tick = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] v);
      @(negedge clk) begin tx_wr = 1; tx_data = v; end
      @(negedge clk) tx_wr = 0;
      @(negedge clk);
   endtask

   task automatic rd();
      @(negedge clk) rx_rd = 1;
      @(negedge clk) rx_rd = 0;
   endtask

   task automatic setup(input int wl, input bit cpol, input bit cpha, input logic [1:0] mode,
                        input bit insel, input bit oe0, input bit oe1, input bit actlow,
                        input bit force_cs, input bit turbo, input int wcnt);
      @(negedge clk) enable = 0;
      repeat (2) @(negedge clk);
      cfg_wlen_m1 = 5'(wl); cfg_cpol = cpol; cfg_cpha = cpha; cfg_mode = mode;
      cfg_in_sel = insel; cfg_oe0 = oe0; cfg_oe1 = oe1; cfg_cs_act_low = actlow;
      cfg_force = force_cs; cfg_turbo = turbo; cfg_wcnt = 16'(wcnt);
      @(negedge clk) enable = 1;
      @(negedge clk);
   endtask

   // one full word of 2W strobes with a slave model on the selected lines
   task automatic do_word(input int w, input logic [31:0] exp_tx, input logic [31:0] slave, input string req);
      logic [31:0] seen = '0;
      int still = 0;
      for (int e = 0; e < 2 * w; e++) begin
         logic prev;
         if ((e % 2) == int'(cfg_cpha)) begin
            logic b;
            b = slave[w - 1 - e / 2];
            if (cfg_in_sel) begin d1_i = b; d0_i = ~b; end
            else begin d0_i = b; d1_i = ~b; end
            seen = {seen[30:0], (cfg_oe1 ? d1_o : d0_o)};
         end
         prev = sclk;
         tick();
         if (sclk == prev) still++;
      end
      chk(seen == (exp_tx & wmask(w)), {req, " line bits"}, seen, exp_tx & wmask(w));
      chk(still == 0, "R2 sclk toggles every strobe", 32'(still), 0);
   endtask

   task automatic t_reset();
      chk(tx_empty == 1, "R11 reset tx_empty", 32'(tx_empty), 1);
      chk(rx_full == 0 && eot == 0, "R11 reset flags", {30'b0, rx_full, eot}, 0);
      chk(cs_o == 1 && sclk == 0, "R11 reset cs/sclk", {30'b0, cs_o, sclk}, 32'h2);
      chk(d0_oe == 0 && d1_oe == 0, "R11 reset lines undriven", {30'b0, d0_oe, d1_oe}, 0);
   endtask

   task automatic t_basic();
      setup(7, 0, 0, 2'b00, 0, 0, 1, 1, 0, 0, 1);
      wr(32'hA5);
      chk(cs_o == 0, "R7 cs active low during word", 32'(cs_o), 0);
      chk(d1_oe == 1 && d0_oe == 0, "R6 only line 1 drives", {30'b0, d0_oe, d1_oe}, 1);
      do_word(8, 32'hA5, 32'h3C, "R1 basic");
      chk(rx_full == 1, "R10 rx_full after word", 32'(rx_full), 1);
      chk(rx_data == 32'h3C, "R10 rx data", rx_data, 32'h3C);
      chk(eot == 1, "R8 eot after one word", 32'(eot), 1);
      rd();
      chk(rx_full == 0, "R10 read clears rx_full", 32'(rx_full), 0);
   endtask

   task automatic t_clock_modes();
      for (int m = 0; m < 4; m++) begin
         setup(11, m[1], m[0], 2'b00, 0, 0, 1, 1, 0, 0, 1);
         chk(sclk == m[1], "R2 idle level", 32'(sclk), 32'(m[1]));
         wr(32'hABC);
         do_word(12, 32'hABC, 32'h5A3, "R2 phase/polarity");
         chk(rx_data == 32'h5A3, "R2 sampled word", rx_data, 32'h5A3);
         chk(sclk == m[1], "R2 back to idle", 32'(sclk), 32'(m[1]));
      end
   endtask

   task automatic t_word_len();
      setup(31, 0, 1, 2'b00, 0, 0, 1, 1, 0, 0, 1);
      wr(32'hDEADBEEF);
      do_word(32, 32'hDEADBEEF, 32'h12345678, "R1 32-bit");
      chk(rx_data == 32'h12345678, "R1 32-bit rx", rx_data, 32'h12345678);
      setup(3, 0, 0, 2'b00, 0, 0, 1, 1, 0, 0, 1);
      wr(32'hFFF5);
      do_word(4, 32'h5, 32'hA, "R1 4-bit upper tx bits dropped");
      chk(rx_data == 32'hA, "R10 4-bit right justified", rx_data, 32'hA);
      setup(1, 0, 0, 2'b00, 0, 0, 1, 1, 0, 0, 1);
      wr(32'h3);
      do_word(4, 32'h3, 32'h9, "R1 field below minimum acts as 4");
      chk(rx_data == 32'h9 && eot == 1, "R1 clamp rx/eot", rx_data, 32'h9);
   endtask

   task automatic t_input_sel();
      setup(7, 0, 0, 2'b00, 1, 1, 0, 1, 0, 0, 1);
      wr(32'h6E);
      chk(d0_oe == 1 && d1_oe == 0, "R6 only line 0 drives", {30'b0, d0_oe, d1_oe}, 2);
      do_word(8, 32'h6E, 32'hC1, "R5 line 1 in");
      chk(rx_data == 32'hC1, "R5 sampled line 1", rx_data, 32'hC1);
      chk(d0_oe == 0, "R6 released after word", 32'(d0_oe), 0);
   endtask

   task automatic t_tx_only();
      setup(7, 0, 0, 2'b10, 0, 0, 1, 1, 0, 0, 1);
      wr(32'h81);
      do_word(8, 32'h81, 32'hFF, "R3 tx only");
      chk(rx_full == 0, "R3 tx only leaves rx_full low", 32'(rx_full), 0);
      chk(eot == 1, "R3 tx only eot", 32'(eot), 1);
   endtask

   task automatic t_rx_only();
      setup(7, 1, 0, 2'b01, 0, 0, 1, 1, 0, 0, 2);
      repeat (3) tick();
      chk(sclk == 1 && cs_o == 1, "R4 no start before write", {30'b0, sclk, cs_o}, 3);
      wr(32'hFF);
      chk(cs_o == 0, "R4 dummy write starts", 32'(cs_o), 0);
      do_word(8, 32'h0, 32'h96, "R4 zeros out w1");
      chk(rx_data == 32'h96, "R4 rx w1", rx_data, 32'h96);
      rd();
      tick();
      do_word(8, 32'h0, 32'h3C, "R4 zeros out w2");
      chk(rx_data == 32'h3C && eot == 1, "R4 rx w2 and eot", rx_data, 32'h3C);
   endtask

   task automatic t_turbo();
      setup(7, 0, 0, 2'b00, 0, 0, 1, 1, 0, 1, 2);
      wr(32'h11);
      wr(32'h22);
      chk(tx_empty == 0, "R10 second word held", 32'(tx_empty), 0);
      do_word(8, 32'h11, 32'h44, "R9 turbo w1");
      chk(rx_data == 32'h44 && cs_o == 0, "R9 rx w1, cs kept", rx_data, 32'h44);
      rd();
      do_word(8, 32'h22, 32'h55, "R9 turbo w2 without gap");
      chk(rx_data == 32'h55 && eot == 1, "R9 rx w2 and eot", rx_data, 32'h55);
   endtask

   task automatic t_gap();
      logic prev;
      setup(7, 0, 1, 2'b00, 0, 0, 1, 0, 0, 0, 0);
      wr(32'hA1);
      wr(32'hB2);
      wr(32'hC3);
      do_word(8, 32'hA1, 32'h0F, "R9 gap w1");
      chk(cs_o == 0, "R7 active-high cs released in gap", 32'(cs_o), 0);
      prev = sclk;
      tick();
      chk(sclk == prev, "R9 gap strobe leaves sclk", 32'(sclk), 32'(prev));
      chk(cs_o == 1, "R7 active-high cs on next word", 32'(cs_o), 1);
      rd();
      do_word(8, 32'hB2, 32'hF0, "R10 write to full holding ignored");
      tick();
      chk(tx_empty == 1 && cs_o == 0, "R10 nothing left after two words", {30'b0, tx_empty, cs_o}, 2);
      chk(eot == 0, "R8 count 0 has no end", 32'(eot), 0);
   endtask

   task automatic t_force_eot();
      logic prev;
      setup(7, 0, 0, 2'b00, 0, 0, 1, 1, 1, 0, 1);
      chk(cs_o == 0, "R7 forced cs before word", 32'(cs_o), 0);
      wr(32'h5A);
      do_word(8, 32'h5A, 32'h77, "R7 forced transfer");
      chk(eot == 1 && cs_o == 0, "R7 forced cs after eot", {30'b0, eot, cs_o}, 2);
      wr(32'h99);
      prev = sclk;
      tick(); tick(); tick();
      chk(sclk == prev && tx_empty == 0, "R8 no word after eot", {30'b0, sclk, tx_empty}, {30'b0, prev, 1'b0});
   endtask

   task automatic t_disable();
      setup(15, 1, 0, 2'b00, 0, 0, 1, 1, 0, 0, 1);
      wr(32'h1234);
      repeat (5) tick();
      @(negedge clk) enable = 0;
      repeat (2) @(negedge clk);
      chk(sclk == 1 && cs_o == 1, "R11 abort idles sclk/cs", {30'b0, sclk, cs_o}, 3);
      chk(d1_oe == 0 && tx_empty == 1 && rx_full == 0, "R11 abort clears",
          {29'b0, d1_oe, tx_empty, rx_full}, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_clock_modes();
      t_word_len();
      t_input_sel();
      t_tx_only();
      t_rx_only();
      t_turbo();
      t_gap();
      t_force_eot();
      t_disable();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule